// File: doc/BRIEF.md
# Multi-Hart Core-Local Timer and Software Interrupt Unit

This block gives each hardware thread (hart) of a multi-hart cluster two machine-level interrupt sources. The first is a timer interrupt, raised when a shared 64-bit real-time counter reaches that hart's 64-bit compare value. The second is a software interrupt that any agent on the register bus can set or clear. The counter starts at zero and advances once for every cycle in which the timebase tick enable is high.

Software reaches the block over a simple 32-bit register bus. Each transfer is a one-cycle strobe that carries an address, a write flag, write data and byte enables. Read data is registered. There are three register regions: one software-interrupt word per hart, one 8-byte compare slot per hart split into low and high words, and a read-only pair of counter words. The hart count, the address width and the base offset of each region are parameters.

A write to one half of a compare slot leaves the other half as it was. The full 64-bit value is compared again on the next clock. A hart can therefore be silenced by writing a large high word even while its low word is still below the counter.

Top module: `hart_timer_ctrl`

## Requirements
- R1: The 64-bit counter resets to zero and increases by exactly one at each clock edge where `tick_en` is high. It holds its value otherwise.
- R2: The counter reads as its low word at `TIME_BASE` and its high word at `TIME_BASE+4`. Writes to either word leave the counter unchanged.
- R3: Hart h owns the software word at `SWI_BASE+4*h`. A write copies bit 0 of the write data into `msip_o[h]`. A read returns `msip_o[h]` in bit 0 with zeros in bits 31:1.
- R4: Hart h owns the compare slot at `CMP_BASE+8*h`, with bits 31:0 at offset 0 and bits 63:32 at offset 4. A write to one half keeps the other half, and a read returns the addressed half.
- R5: `mtip_o[h]` is high exactly when the hart's compare value is less than or equal to the counter, as a full 64-bit unsigned comparison. It follows the register values with one cycle of delay.
- R6: After reset every compare value is zero, every `msip_o` bit is zero, and every `mtip_o` bit is one.
- R7: A read returns zero at any address outside the three regions, at any address whose bits 1:0 are not zero, and at any slot beyond hart `NUM_HARTS-1`. A write to any such address changes no state.
- R8: A write takes effect only when `bus_be` is 4'b1111. A write with any other byte-enable pattern is ignored.
- R9: Read data appears on `bus_rdata` in the cycle after a read strobe and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; the counter advances when high |
| bus_sel | input | 1 | Transfer strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_be | input | 4 | Byte enables; writes need all four set |
| bus_rdata | output | 32 | Registered read data |
| msip_o | output | NUM_HARTS | Software interrupt per hart |
| mtip_o | output | NUM_HARTS | Timer interrupt per hart |

## Verification
The bench programs a compare value whose low word is below the counter but whose high word is nonzero. A design that compares only 32 bits would raise the timer interrupt there. It then steps the counter one tick at a time up to the compare value. This catches a strict less-than compare, which misses the equality cycle, and an unregistered output, which moves a cycle early. Writes to the hart slot just past the last hart, to misaligned offsets and to the counter words are each followed by read-back and interrupt checks. These catch a decoder that wraps into hart 0 or that accepts a write to the counter. Partial byte-enable writes and half-word compare updates confirm that the untouched half and the other harts keep their state.

// File: rtl/htc_pkg.sv
package htc_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned CNT_W  = 64;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_SWI  = 2'd1,
      RGN_CMP  = 2'd2,
      RGN_TIME = 2'd3
   } htc_rgn_e;
endpackage

// File: rtl/htc_decode.sv
module htc_decode
   import htc_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 2,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SWI_BASE  = 32'h0000,
   parameter int unsigned CMP_BASE  = 32'h4000,
   parameter int unsigned TIME_BASE = 32'hBFF8
) (
   input  logic [ADDR_W-1:0]    addr,
   output htc_rgn_e             rgn,
   output logic                 upper,
   output logic [NUM_HARTS-1:0] hart_hit
);
   localparam logic [ADDR_W-1:0] SWI_B    = ADDR_W'(SWI_BASE);
   localparam logic [ADDR_W-1:0] CMP_B    = ADDR_W'(CMP_BASE);
   localparam logic [ADDR_W-1:0] TIME_LO  = ADDR_W'(TIME_BASE);
   localparam logic [ADDR_W-1:0] TIME_HI  = ADDR_W'(TIME_BASE + 4);
   localparam logic [ADDR_W-1:0] SWI_SPAN = ADDR_W'(4 * NUM_HARTS);
   localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * NUM_HARTS);

   logic [ADDR_W-1:0] swi_off;
   logic [ADDR_W-1:0] cmp_off;
   logic              aligned;
   logic              swi_in;
   logic              cmp_in;
   logic              time_lo;
   logic              time_hi;

   // Offsets wrap below the base, so a single upper-bound test suffices.
   assign swi_off = addr - SWI_B;
   assign cmp_off = addr - CMP_B;
   assign aligned = (addr[1:0] == 2'b00);
   assign swi_in  = aligned && (swi_off < SWI_SPAN);
   assign cmp_in  = aligned && (cmp_off < CMP_SPAN);
   assign time_lo = (addr == TIME_LO);
   assign time_hi = (addr == TIME_HI);

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
      assign hart_hit[h] =
         (swi_in && (swi_off[ADDR_W-1:2] == (ADDR_W-2)'(h))) ||
         (cmp_in && (cmp_off[ADDR_W-1:3] == (ADDR_W-3)'(h)));
   end

   always_comb begin
      rgn   = RGN_NONE;
      upper = 1'b0;
      if (swi_in) begin
         rgn = RGN_SWI;
      end else if (cmp_in) begin
         rgn   = RGN_CMP;
         upper = cmp_off[2];
      end else if (time_lo || time_hi) begin
         rgn   = RGN_TIME;
         upper = time_hi;
      end
   end
endmodule

// File: rtl/htc_mtime.sv
module htc_mtime #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick_en) begin
         count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/htc_hart_slot.sv
module htc_hart_slot
   import htc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] mtime,
   input  logic             swi_we,
   input  logic             swi_val,
   input  logic             cmp_we_lo,
   input  logic             cmp_we_hi,
   input  logic [WORD_W-1:0] wdata,
   output logic             msip,
   output logic [CNT_W-1:0] cmp,
   output logic             mtip
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msip <= 1'b0;
         cmp  <= '0;
         mtip <= 1'b1;
      end else begin
         if (swi_we) begin
            msip <= swi_val;
         end
         if (cmp_we_lo) begin
            cmp[WORD_W-1:0] <= wdata;
         end
         if (cmp_we_hi) begin
            cmp[CNT_W-1:WORD_W] <= wdata;
         end
         mtip <= (cmp <= mtime);
      end
   end
endmodule

// File: rtl/hart_timer_ctrl.sv
module hart_timer_ctrl
   import htc_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 2,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SWI_BASE  = 32'h0000,
   parameter int unsigned CMP_BASE  = 32'h4000,
   parameter int unsigned TIME_BASE = 32'hBFF8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [3:0]           bus_be,
   output logic [31:0]          bus_rdata,
   output logic [NUM_HARTS-1:0] msip_o,
   output logic [NUM_HARTS-1:0] mtip_o
);
   localparam longint unsigned SPACE = 64'd1 << ADDR_W;

   if (NUM_HARTS < 1) begin : g_bad_harts
      $error("hart_timer_ctrl: NUM_HARTS must be at least 1");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("hart_timer_ctrl: ADDR_W must lie in 8..32");
   end
   if ((SWI_BASE % 4) != 0 || (CMP_BASE % 8) != 0 || (TIME_BASE % 8) != 0) begin : g_bad_align
      $error("hart_timer_ctrl: region base misaligned");
   end
   if (64'(SWI_BASE) + 64'(4 * NUM_HARTS) > SPACE ||
       64'(CMP_BASE) + 64'(8 * NUM_HARTS) > SPACE ||
       64'(TIME_BASE) + 64'd8 > SPACE) begin : g_bad_fit
      $error("hart_timer_ctrl: region exceeds address space");
   end

   htc_rgn_e                         dec_rgn;
   logic                             dec_upper;
   logic [NUM_HARTS-1:0]             dec_hit;
   logic [CNT_W-1:0]                 mtime_q;
   logic [NUM_HARTS-1:0][CNT_W-1:0]  cmp_val;
   logic                             wr_ok;
   logic                             rd_req;
   logic [WORD_W-1:0]                rd_mux;

   htc_decode #(
      .NUM_HARTS (NUM_HARTS),
      .ADDR_W    (ADDR_W),
      .SWI_BASE  (SWI_BASE),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) dec_i (
      .addr     (bus_addr),
      .rgn      (dec_rgn),
      .upper    (dec_upper),
      .hart_hit (dec_hit)
   );

   htc_mtime #(.CNT_W(CNT_W)) mtime_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .count   (mtime_q)
   );

   assign wr_ok  = bus_sel && bus_we && (bus_be == 4'b1111);
   assign rd_req = bus_sel && !bus_we;

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic swi_we_h;
      logic lo_we_h;
      logic hi_we_h;

      assign swi_we_h = wr_ok && dec_hit[h] && (dec_rgn == RGN_SWI);
      assign lo_we_h  = wr_ok && dec_hit[h] && (dec_rgn == RGN_CMP) && !dec_upper;
      assign hi_we_h  = wr_ok && dec_hit[h] && (dec_rgn == RGN_CMP) && dec_upper;

      htc_hart_slot slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .mtime     (mtime_q),
         .swi_we    (swi_we_h),
         .swi_val   (bus_wdata[0]),
         .cmp_we_lo (lo_we_h),
         .cmp_we_hi (hi_we_h),
         .wdata     (bus_wdata),
         .msip      (msip_o[h]),
         .cmp       (cmp_val[h]),
         .mtip      (mtip_o[h])
      );
   end

   always_comb begin
      rd_mux = '0;
      unique case (dec_rgn)
         RGN_SWI: begin
            for (int h = 0; h < NUM_HARTS; h++) begin
               if (dec_hit[h]) rd_mux = rd_mux | {31'b0, msip_o[h]};
            end
         end
         RGN_CMP: begin
            for (int h = 0; h < NUM_HARTS; h++) begin
               if (dec_hit[h]) begin
                  rd_mux = rd_mux | (dec_upper ? cmp_val[h][CNT_W-1:WORD_W]
                                               : cmp_val[h][WORD_W-1:0]);
               end
            end
         end
         RGN_TIME: rd_mux = dec_upper ? mtime_q[CNT_W-1:WORD_W] : mtime_q[WORD_W-1:0];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= rd_req ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/htc_chk.sv
module htc_chk
   import htc_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick_en,
   input logic                            bus_sel,
   input logic                            bus_we,
   input logic [3:0]                      bus_be,
   input logic                            wbit0,
   input htc_rgn_e                        rgn,
   input logic [NUM_HARTS-1:0]            hart_hit,
   input logic [CNT_W-1:0]                mtime,
   input logic [NUM_HARTS-1:0][CNT_W-1:0] cmp_val,
   input logic [NUM_HARTS-1:0]            msip,
   input logic [NUM_HARTS-1:0]            mtip,
   input logic [31:0]                     rdata
);
   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (mtime == $past(mtime) + 64'd1));

   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en) |=> $stable(mtime));

   // R2
   time_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && rgn == RGN_TIME && !tick_en) |=> $stable(mtime));

   // R7
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && rgn == RGN_NONE) |=> (rdata == 32'h0));

   // R9
   idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_sel && !bus_we)) |=> (rdata == 32'h0));

   // R8
   partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_be != 4'b1111) |=> ($stable(msip) && $stable(cmp_val)));

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hchk
      // R5
      mtip_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (mtip[h] == ($past(cmp_val[h]) <= $past(mtime))));

      // R3
      swi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_be == 4'b1111 && rgn == RGN_SWI && hart_hit[h])
         |=> (msip[h] == $past(wbit0)));
   end
endmodule

bind hart_timer_ctrl htc_chk #(.NUM_HARTS(NUM_HARTS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .bus_sel  (bus_sel),
   .bus_we   (bus_we),
   .bus_be   (bus_be),
   .wbit0    (bus_wdata[0]),
   .rgn      (dec_rgn),
   .hart_hit (dec_hit),
   .mtime    (mtime_q),
   .cmp_val  (cmp_val),
   .msip     (msip_o),
   .mtip     (mtip_o),
   .rdata    (bus_rdata)
);

// File: tb/hart_timer_ctrl_tb_top.sv
module hart_timer_ctrl_tb_top;
   localparam int unsigned NH  = 2;
   localparam int unsigned AW  = 16;
   localparam logic [15:0] SWI = 16'h0000;
   localparam logic [15:0] CMP = 16'h4000;
   localparam logic [15:0] TIM = 16'hBFF8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [3:0]    bus_be = 4'hF;
   logic [31:0]   bus_rdata;
   logic [NH-1:0] msip_o;
   logic [NH-1:0] mtip_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   hart_timer_ctrl #(
      .NUM_HARTS (NH),
      .ADDR_W    (AW),
      .SWI_BASE  (32'h0000),
      .CMP_BASE  (32'h4000),
      .TIME_BASE (32'hBFF8)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .bus_rdata (bus_rdata),
      .msip_o    (msip_o),
      .mtip_o    (mtip_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R6 mtip after reset", 32'(mtip_o), 32'h3);
      check("R6 msip after reset", 32'(msip_o), 32'h0);
      check("R9 rdata idle", bus_rdata, 32'h0);
      bus_read(TIM, d);      check("R1 counter at reset", d, 32'h0);
      bus_read(CMP, d);      check("R6 cmp0 lo reset", d, 32'h0);
      bus_read(CMP + 12, d); check("R6 cmp1 hi reset", d, 32'h0);
   endtask

   task automatic t_counter();
      logic [31:0] d;
      ticks(10);
      bus_read(TIM, d);     check("R1 counter after 10 ticks", d, 32'd10);
      bus_read(TIM + 4, d); check("R2 counter hi word", d, 32'h0);
      bus_write(TIM, 32'hFFFF_FFFF, 4'hF);
      bus_write(TIM + 4, 32'h5, 4'hF);
      bus_read(TIM, d);     check("R2 lo write ignored", d, 32'd10);
      bus_read(TIM + 4, d); check("R2 hi write ignored", d, 32'h0);
   endtask

   task automatic t_swi();
      logic [31:0] d;
      bus_write(SWI + 4, 32'h1, 4'hF);
      check("R3 set hart1", 32'(msip_o), 32'h2);
      bus_read(SWI + 4, d); check("R3 read hart1", d, 32'h1);
      bus_read(SWI, d);     check("R3 read hart0", d, 32'h0);
      bus_write(SWI + 4, 32'hFFFF_FFFE, 4'hF);
      check("R3 bit0 clears hart1", 32'(msip_o), 32'h0);
      bus_write(SWI, 32'h3, 4'hF);
      check("R3 set hart0", 32'(msip_o), 32'h1);
      bus_read(SWI, d);     check("R3 read hart0 set", d, 32'h1);
   endtask

   task automatic t_be();
      logic [31:0] d;
      bus_write(SWI + 4, 32'h1, 4'h1);
      check("R8 partial swi write", 32'(msip_o), 32'h1);
      bus_write(CMP, 32'h1234, 4'h3);
      bus_read(CMP, d); check("R8 partial cmp write", d, 32'h0);
   endtask

   task automatic t_cmp();
      logic [31:0] d;
      bus_write(CMP, 32'd20, 4'hF);
      check("R5 mtip lags one cycle", 32'(mtip_o), 32'h3);
      @(negedge clk);
      check("R5 mtip0 drops", 32'(mtip_o), 32'h2);
      bus_read(CMP, d);     check("R4 cmp0 lo", d, 32'd20);
      bus_read(CMP + 4, d); check("R4 cmp0 hi", d, 32'h0);
      bus_write(CMP + 4, 32'h1, 4'hF);
      bus_read(CMP, d);     check("R4 lo kept on hi write", d, 32'd20);
      bus_read(CMP + 4, d); check("R4 hi written", d, 32'h1);
      bus_write(CMP, 32'd5, 4'hF);
      @(negedge clk);
      check("R5 64-bit compare with hi set", 32'(mtip_o), 32'h2);
      bus_write(CMP + 4, 32'h0, 4'hF);
      @(negedge clk);
      check("R5 cmp below counter", 32'(mtip_o), 32'h3);
      bus_write(CMP, 32'd20, 4'hF);
      @(negedge clk);
      check("R5 cmp above counter", 32'(mtip_o), 32'h2);
      bus_read(CMP + 8, d); check("R4 hart1 untouched", d, 32'h0);
   endtask

   task automatic t_cross();
      ticks(9);
      @(negedge clk);
      check("R5 counter 19 below cmp", 32'(mtip_o), 32'h2);
      ticks(1);
      check("R5 lag at equality", 32'(mtip_o), 32'h2);
      @(negedge clk);
      check("R5 equal raises mtip", 32'(mtip_o), 32'h3);
   endtask

   task automatic t_bad();
      logic [31:0] d;
      bus_read(CMP + 2, d);    check("R7 misaligned read", d, 32'h0);
      bus_read(SWI + 8, d);    check("R7 hart beyond count swi", d, 32'h0);
      bus_read(CMP + 16, d);   check("R7 hart beyond count cmp", d, 32'h0);
      bus_read(16'h2000, d);   check("R7 unmapped read", d, 32'h0);
      bus_read(TIM + 8, d);    check("R7 past counter read", d, 32'h0);
      @(negedge clk);
      check("R9 rdata clears after read", bus_rdata, 32'h0);
      bus_write(SWI + 8, 32'h1, 4'hF);
      check("R7 out-of-range swi write", 32'(msip_o), 32'h1);
      bus_write(CMP + 20, 32'hFFFF_FFFF, 4'hF);
      bus_write(CMP + 1, 32'hFFFF_FFFF, 4'hF);
      @(negedge clk);
      check("R7 ignored writes keep mtip", 32'(mtip_o), 32'h3);
      bus_read(CMP + 4, d);    check("R7 cmp0 hi unchanged", d, 32'h0);
      bus_read(CMP, d);        check("R7 cmp0 lo unchanged", d, 32'd20);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_counter();
      t_swi();
      t_be();
      t_cmp();
      t_cross();
      t_bad();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule